// File: doc/BRIEF.md
# Ethernet Transmit Framer with Collision Backoff

This block turns a buffered frame body into a byte stream for a media-independent transmit path. After a `start` pulse carrying a byte length and a checksum-disable flag, it reads the body word by word through an index/data port. The body source answers in the same cycle and flags when a requested word is not there yet. On the line the frame appears as a preamble and a start delimiter, then the body, zero padding up to the minimum body size, and the complemented frame check sequence.

The block keeps a minimum idle gap between frames. In full-duplex mode it starts as soon as that gap allows. In half-duplex mode it first waits for carrier sense to drop and then waits a further gap. A collision seen during transmission replaces the rest of the frame with four jam bytes taken from a configurable word. The block then waits a random number of slot times, using truncated binary exponential backoff driven by an internal LFSR, and retries from the preamble. When the attempt limit is reached, the frame is dropped and an error pulse is raised. A body word that is missing when needed ends the frame with the same four jam bytes, which leaves a wrong checksum on the line, and `tx_err` is held high during them.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset `tx_en`, `tx_err`, `busy`, `done` and `excess_col` are all 0.
- R2: Every attempt starts with 7 bytes of 0x55 followed by one byte of 0xD5, all with `tx_en` high.
- R3: Body byte i is lane i%4 of word i/4 (`word_data[7:0]` is lane 0). Body bytes go out in order right after 0xD5.
- R4: A body shorter than 60 bytes is followed by 0x00 bytes until 60 bytes have been sent.
- R5: The sequence after the body and padding is the one's complement of the reflected CRC-32 (polynomial 0x04C11DB7, preset all ones, over body and padding), least significant byte first. With `no_crc`=1 the frame ends after body and padding.
- R6: At least IFG_CYC idle byte cycles separate any two bursts of `tx_en`. In full-duplex mode `crs` and `col` have no effect, and a frame begins within IFG_CYC+3 cycles of `start` once the gap has passed.
- R7: In half-duplex mode no frame begins while `crs` is high, nor before `crs` has been low for IFG_CYC cycles.
- R8: In half-duplex mode, `col` high during preamble, delimiter, body, padding or check sequence makes the next four bytes `jam_word` lanes 0..3. The frame then stops, and a later attempt resends it from the preamble.
- R9: After collision n, the idle time before the retry is at least IFG_CYC and at most (2^min(n,10)-1)*SLOT_CYC + IFG_CYC + 3 cycles.
- R10: The jam of the 16th collision (MAX_TRY) is not followed by a retry. `excess_col` pulses once together with its last jam byte, and `done` does not pulse.
- R11: If `word_avail` is 0 when a body byte is due, four `jam_word` bytes go out with `tx_err`=1 in place of the rest of the frame. The frame is not retried and `done` does not pulse.
- R12: `done` pulses for one cycle together with the last byte of a frame that completed normally. `tx_err` is never high without `tx_en`.
- R13: `start` is accepted only while `busy` is 0. A `start` during a frame creates no extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one byte time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| half_duplex | input | 1 | 1 selects carrier deferral and collision handling |
| start | input | 1 | Request to send one frame |
| frame_len | input | LEN_W | Body length in bytes, sampled with `start` |
| no_crc | input | 1 | Suppress the check sequence, sampled with `start` |
| jam_word | input | 32 | Source of the four jam bytes |
| word_idx | output | LEN_W-2 | Index of the body word currently needed |
| word_data | input | 32 | Body word at `word_idx` |
| word_avail | input | 1 | `word_data` is present; 0 means underrun |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| tx_en | output | 1 | Byte valid on `tx_data` |
| tx_data | output | 8 | Transmitted byte |
| tx_err | output | 1 | Marks bytes sent after an underrun |
| busy | output | 1 | A frame is pending or in progress |
| done | output | 1 | Frame completed without error |
| excess_col | output | 1 | Frame dropped after too many collisions |

## Verification
The bench keeps LEN_W=12, IFG_CYC=12, MAX_TRY=16 and BO_CAP=10, but shrinks SLOT_CYC to 2. With that value a frame that collides sixteen times, including the backoff windows already capped at 1023 slots, fits in a short run. Each backoff can then be checked against its window and the drop after the limit can be observed. The lower gap bound and the carrier deferral do not depend on the slot length, so they are checked at the same timing a full-size build would have.

// File: rtl/eth_txf_pkg.sv
package eth_txf_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEFER,
        ST_PRE,
        ST_SFD,
        ST_DATA,
        ST_PAD,
        ST_FCS,
        ST_JAM,
        ST_BACKOFF
    } txf_state_e;

    localparam logic [7:0]  PRE_BYTE      = 8'h55;
    localparam logic [7:0]  SFD_BYTE      = 8'hD5;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

endpackage

// File: rtl/eth_txf_crc.sv
// One byte of reflected CRC-32, least significant bit first.
module eth_txf_crc
    import eth_txf_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_out
);

    always_comb begin
        crc_out = crc_in;
        for (int b = 0; b < 8; b++) begin
            if (crc_out[0] ^ byte_in[b]) begin
                crc_out = (crc_out >> 1) ^ CRC_POLY_REFL;
            end else begin
                crc_out = crc_out >> 1;
            end
        end
    end

endmodule

// File: rtl/eth_txf_lfsr.sv
// Free-running Galois LFSR feeding the backoff choice.
module eth_txf_lfsr #(
    parameter int          W     = 16,
    parameter int          OUT_W = 10,
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter logic [15:0] TAPS  = 16'hB400
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] value
);

    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED[W-1:0];
        end else if (state_q[0]) begin
            state_q <= (state_q >> 1) ^ TAPS[W-1:0];
        end else begin
            state_q <= state_q >> 1;
        end
    end

    assign value = state_q[OUT_W-1:0];

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
    import eth_txf_pkg::*;
#(
    parameter int          LEN_W     = 12,
    parameter int          PRE_BYTES = 7,
    parameter int          MIN_BODY  = 60,
    parameter int          IFG_CYC   = 12,
    parameter int          SLOT_CYC  = 64,
    parameter int          MAX_TRY   = 16,
    parameter int          BO_CAP    = 10,
    parameter logic [15:0] LFSR_SEED = 16'hACE1,
    localparam int         IDX_W     = LEN_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             half_duplex,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             no_crc,
    input  logic [31:0]      jam_word,
    output logic [IDX_W-1:0] word_idx,
    input  logic [31:0]      word_data,
    input  logic             word_avail,
    input  logic             crs,
    input  logic             col,
    output logic             tx_en,
    output logic [7:0]       tx_data,
    output logic             tx_err,
    output logic             busy,
    output logic             done,
    output logic             excess_col
);

    localparam int SUB_W  = 3;
    localparam int GAP_W  = $clog2(IFG_CYC + 1);
    localparam int SLOT_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
    localparam int TRY_W  = $clog2(MAX_TRY + 1);

    typedef struct packed {
        txf_state_e       st;
        logic [LEN_W-1:0] len;
        logic             nocrc;
        logic [LEN_W-1:0] cnt;
        logic [SUB_W-1:0] sub;
        logic [31:0]      crc;
        logic [TRY_W-1:0] tries;
        logic [BO_CAP-1:0] bo;
        logic [SLOT_W-1:0] slot;
        logic [GAP_W-1:0] gap;
        logic             und;
        logic             en;
        logic [7:0]       data;
        logic             err;
        logic             fin;
        logic             exc;
    } txf_regs_t;

    txf_regs_t q, d;

    logic [BO_CAP-1:0] rnd;
    logic [BO_CAP-1:0] bo_mask;
    logic [TRY_W-1:0]  tries_nxt;
    logic [7:0]        body_byte;
    logic [7:0]        crc_byte;
    logic [31:0]       crc_upd;
    logic              on_line;

    eth_txf_lfsr #(
        .W     (16),
        .OUT_W (BO_CAP),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    eth_txf_crc u_crc (
        .crc_in  (q.crc),
        .byte_in (crc_byte),
        .crc_out (crc_upd)
    );

    assign word_idx  = q.cnt[LEN_W-1:2];
    assign body_byte = word_data[{q.cnt[1:0], 3'b000} +: 8];
    assign crc_byte  = (q.st == ST_DATA) ? body_byte : 8'h00;
    assign on_line   = (q.st == ST_PRE) || (q.st == ST_SFD) || (q.st == ST_DATA)
                    || (q.st == ST_PAD) || (q.st == ST_FCS);
    assign tries_nxt = q.tries + TRY_W'(1);

    always_comb begin
        for (int i = 0; i < BO_CAP; i++) begin
            bo_mask[i] = (i < int'(tries_nxt));
        end
    end

    always_comb begin
        d      = q;
        d.en   = 1'b0;
        d.err  = 1'b0;
        d.fin  = 1'b0;
        d.exc  = 1'b0;
        d.data = 8'h00;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_DEFER;
                    d.len   = frame_len;
                    d.nocrc = no_crc;
                    d.tries = '0;
                end
            end
            ST_DEFER: begin
                if (q.gap == '0 && !(half_duplex && crs)) begin
                    d.st  = ST_PRE;
                    d.sub = '0;
                end
            end
            ST_PRE: begin
                d.en   = 1'b1;
                d.data = PRE_BYTE;
                d.sub  = q.sub + SUB_W'(1);
                if (q.sub == SUB_W'(PRE_BYTES - 1)) d.st = ST_SFD;
            end
            ST_SFD: begin
                d.en   = 1'b1;
                d.data = SFD_BYTE;
                d.cnt  = '0;
                d.crc  = '1;
                d.und  = 1'b0;
                d.st   = (q.len == '0) ? ST_PAD : ST_DATA;
            end
            ST_DATA: begin
                d.en = 1'b1;
                if (!word_avail) begin
                    d.data = jam_word[7:0];
                    d.err  = 1'b1;
                    d.und  = 1'b1;
                    d.sub  = SUB_W'(1);
                    d.st   = ST_JAM;
                end else begin
                    d.data = body_byte;
                    d.crc  = crc_upd;
                    d.cnt  = q.cnt + LEN_W'(1);
                    if (q.cnt + LEN_W'(1) == q.len) begin
                        if (q.len < LEN_W'(MIN_BODY)) begin
                            d.st = ST_PAD;
                        end else if (q.nocrc) begin
                            d.st  = ST_IDLE;
                            d.fin = 1'b1;
                        end else begin
                            d.st  = ST_FCS;
                            d.sub = '0;
                        end
                    end
                end
            end
            ST_PAD: begin
                d.en  = 1'b1;
                d.crc = crc_upd;
                d.cnt = q.cnt + LEN_W'(1);
                if (q.cnt + LEN_W'(1) == LEN_W'(MIN_BODY)) begin
                    if (q.nocrc) begin
                        d.st  = ST_IDLE;
                        d.fin = 1'b1;
                    end else begin
                        d.st  = ST_FCS;
                        d.sub = '0;
                    end
                end
            end
            ST_FCS: begin
                d.en   = 1'b1;
                d.data = ~q.crc[{q.sub[1:0], 3'b000} +: 8];
                d.sub  = q.sub + SUB_W'(1);
                if (q.sub == SUB_W'(3)) begin
                    d.st  = ST_IDLE;
                    d.fin = 1'b1;
                end
            end
            ST_JAM: begin
                d.en   = 1'b1;
                d.data = jam_word[{q.sub[1:0], 3'b000} +: 8];
                d.err  = q.und;
                d.sub  = q.sub + SUB_W'(1);
                if (q.sub == SUB_W'(3)) begin
                    if (q.und) begin
                        d.st = ST_IDLE;
                    end else if (tries_nxt == TRY_W'(MAX_TRY)) begin
                        d.st  = ST_IDLE;
                        d.exc = 1'b1;
                    end else begin
                        d.tries = tries_nxt;
                        d.bo    = rnd & bo_mask;
                        d.slot  = '0;
                        d.st    = ST_BACKOFF;
                    end
                end
            end
            ST_BACKOFF: begin
                if (q.bo == '0) begin
                    d.st = ST_DEFER;
                end else if (q.slot == SLOT_W'(SLOT_CYC - 1)) begin
                    d.slot = '0;
                    d.bo   = q.bo - BO_CAP'(1);
                end else begin
                    d.slot = q.slot + SLOT_W'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // Collision wins over every other outcome of a transmitting cycle.
        if (half_duplex && col && on_line) begin
            d.en   = 1'b1;
            d.data = jam_word[7:0];
            d.err  = 1'b0;
            d.und  = 1'b0;
            d.fin  = 1'b0;
            d.sub  = SUB_W'(1);
            d.st   = ST_JAM;
        end

        if (d.en || (half_duplex && crs)) begin
            d.gap = GAP_W'(IFG_CYC);
        end else if (q.gap != '0) begin
            d.gap = q.gap - GAP_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.gap <= GAP_W'(IFG_CYC);
        end else begin
            q <= d;
        end
    end

    assign tx_en      = q.en;
    assign tx_data    = q.data;
    assign tx_err     = q.err;
    assign done       = q.fin;
    assign excess_col = q.exc;
    assign busy       = (q.st != ST_IDLE);

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
    parameter int IFG_CYC = 12
) (
    input logic clk,
    input logic rst_n,
    input logic half_duplex,
    input logic crs,
    input logic tx_en,
    input logic tx_err,
    input logic done,
    input logic excess_col
);

    logic [15:0] idle_cnt;
    logic [15:0] quiet_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt  <= '0;
            quiet_cnt <= '0;
        end else begin
            idle_cnt  <= tx_en ? '0 : ((idle_cnt == '1) ? idle_cnt : idle_cnt + 16'd1);
            quiet_cnt <= crs ? '0 : ((quiet_cnt == '1) ? quiet_cnt : quiet_cnt + 16'd1);
        end
    end

    AST_ERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> tx_en); // R12

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tx_en && !tx_err && !excess_col)); // R12

    AST_EXC_ON_JAM: assert property (@(posedge clk) disable iff (!rst_n)
        excess_col |-> (tx_en && !tx_err)); // R10

    AST_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (idle_cnt >= 16'(IFG_CYC))); // R6

    AST_CRS_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_en) && half_duplex) |-> (quiet_cnt >= 16'(IFG_CYC))); // R7

endmodule

bind eth_tx_framer eth_tx_framer_chk #(
    .IFG_CYC (IFG_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_duplex (half_duplex),
    .crs         (crs),
    .tx_en       (tx_en),
    .tx_err      (tx_err),
    .done        (done),
    .excess_col  (excess_col)
);

// File: tb/eth_tx_framer_bench.sv
`timescale 1ns/1ps
module eth_tx_framer_bench;

    localparam int LEN_W   = 12;
    localparam int IFG     = 12;
    localparam int SLOT    = 2;
    localparam int MAXT    = 16;
    localparam logic [31:0] JAM = 32'hC3B2A190;

    typedef struct {
        logic [8:0] v;
        int         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_duplex = 1'b0;
    logic start = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic no_crc = 1'b0;
    logic [LEN_W-3:0] word_idx;
    logic [31:0] word_data;
    logic word_avail;
    logic crs = 1'b0;
    logic col = 1'b0;
    logic tx_en, tx_err, busy, done, excess_col;
    logic [7:0] tx_data;

    logic [7:0] mem [0:255];
    exp_t exp_q [$];
    int total = 0, bad = 0, cyc = 0;
    int avail_words = 100000;
    int idle = 1000, quiet = 0, nb = 0, tries = 0, col_left = 0, col_at = 0;
    int ndone = 0, nexc = 0, nfr = 0, t_first = 0, t_start = 0, bo_max = 0;
    int cur_len = 0;
    bit cur_nocrc = 0, chk_bo = 0, finished = 0;
    logic prev_en = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    eth_tx_framer #(.LEN_W(LEN_W), .IFG_CYC(IFG), .SLOT_CYC(SLOT), .MAX_TRY(MAXT)) u_eth_tx_framer (
        .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .start(start),
        .frame_len(frame_len), .no_crc(no_crc), .jam_word(JAM), .word_idx(word_idx),
        .word_data(word_data), .word_avail(word_avail), .crs(crs), .col(col),
        .tx_en(tx_en), .tx_data(tx_data), .tx_err(tx_err), .busy(busy),
        .done(done), .excess_col(excess_col)
    );

    always_comb begin
        for (int k = 0; k < 4; k++) word_data[8*k +: 8] = mem[(4 * int'(word_idx) + k) % 256];
        word_avail = (int'(word_idx) < avail_words);
    end

    function automatic string rname(int t);
        case (t)
            2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   8: return "R8";   11: return "R11";
            default: return "R?";
        endcase
    endfunction

    function automatic void chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endfunction

    function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic fb;
            fb = c[0] ^ b[i];
            c = c >> 1;
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c;
    endfunction

    function automatic void push(logic err, logic [7:0] b, int tag);
        exp_t e;
        e.v = {err, b};
        e.tag = tag;
        exp_q.push_back(e);
    endfunction

    function automatic void push_jam(logic err, int tag);
        for (int k = 0; k < 4; k++) push(err, JAM[8*k +: 8], tag);
    endfunction

    function automatic void push_frame(int len, bit nocrc, int avail);
        logic [31:0] c;
        int body;
        c = '1;
        for (int i = 0; i < 7; i++) push(1'b0, 8'h55, 2);
        push(1'b0, 8'hD5, 2);
        body = (len < 60) ? 60 : len;
        for (int i = 0; i < body; i++) begin
            logic [7:0] b;
            if (i < len && (i / 4) >= avail) begin
                push_jam(1'b1, 11);
                return;
            end
            b = (i < len) ? mem[i % 256] : 8'h00;
            push(1'b0, b, (i < len) ? 3 : 4);
            c = crc_step(c, b);
        end
        if (!nocrc) for (int k = 0; k < 4; k++) push(1'b0, ~c[8*k +: 8], 5);
    endfunction

    // Reference model: expected byte stream and timing windows, checked each clock.
    always @(negedge clk) begin
        col = 1'b0;
        if (rst_n) begin
            if (tx_en) begin
                if (!prev_en) begin
                    nb = 0;
                    nfr++;
                    t_first = cyc;
                    chk(idle >= IFG, "R6", "idle cycles before frame", idle, IFG);
                    if (half_duplex) chk(quiet >= IFG, "R7", "quiet carrier cycles", quiet, IFG);
                    if (chk_bo) begin
                        chk(idle <= bo_max, "R9", "backoff idle upper bound", idle, bo_max);
                        chk_bo = 0;
                    end
                end
                if (exp_q.size() == 0) begin
                    chk(0, "R13", "unexpected byte", int'(tx_data), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk({tx_err, tx_data} == e.v, rname(e.tag), "line byte",
                        int'({tx_err, tx_data}), int'(e.v));
                end
                nb++;
                if (col_left > 0 && nb == col_at) begin
                    col = 1'b1;
                    col_left--;
                    if (half_duplex) begin
                        int n;
                        exp_q.delete();
                        push_jam(1'b0, 8);
                        tries++;
                        if (tries < MAXT) begin
                            push_frame(cur_len, cur_nocrc, avail_words);
                            n = (tries < 10) ? tries : 10;
                            bo_max = ((1 << n) - 1) * SLOT + IFG + 3;
                            chk_bo = 1;
                        end
                    end
                end
                idle = 0;
            end else begin
                idle++;
            end
            quiet = crs ? 0 : quiet + 1;
            if (done) ndone++;
            if (excess_col) nexc++;
            prev_en = tx_en;
        end
    end

    task automatic send(int len, bit nocrc);
        cur_len = len;
        cur_nocrc = nocrc;
        push_frame(len, nocrc, avail_words);
        @(posedge clk); #1;
        start = 1'b1;
        frame_len = LEN_W'(len);
        no_crc = nocrc;
        t_start = cyc;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while ((busy || tx_en || exp_q.size() != 0) && n < 60000);
        #1;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_en == 0 && tx_err == 0, "R1", "tx lines in reset", int'(tx_en), 0);
        chk(busy == 0 && done == 0 && excess_col == 0, "R1", "status in reset", int'(busy), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (20) @(posedge clk);

        // Short frame, padding and checksum; a second start mid-frame is ignored.
        ndone = 0;
        send(20, 0);
        repeat (30) @(posedge clk);
        #1 start = 1'b1; frame_len = 5;
        @(posedge clk); #1 start = 1'b0;
        wait_idle();
        repeat (40) @(posedge clk);
        chk(nfr == 1, "R13", "frames after busy start", nfr, 1);
        chk(ndone == 1, "R12", "done pulses", ndone, 1);

        // Full duplex, carrier high ignored, long body then back-to-back no-CRC.
        crs = 1'b1;
        send(70, 0);
        wait_idle();
        chk(t_first - t_start <= IFG + 3, "R6", "full-duplex start latency", t_first - t_start, IFG + 3);
        send(60, 1);
        wait_idle();
        send(3, 1);
        wait_idle();
        crs = 1'b0;
        chk(ndone == 4, "R12", "done pulses", ndone, 4);

        // Full duplex: collision input ignored.
        col_left = 1; col_at = 12;
        send(16, 0);
        wait_idle();
        chk(ndone == 5, "R6", "full-duplex collision ignored", ndone, 5);

        // Half duplex: deferral behind carrier.
        half_duplex = 1'b1;
        crs = 1'b1;
        repeat (5) @(posedge clk);
        send(10, 0);
        repeat (40) @(posedge clk);
        chk(nfr == 5, "R7", "no frame while carrier high", nfr, 5);
        #1 crs = 1'b0;
        wait_idle();
        chk(ndone == 6, "R7", "deferred frame done", ndone, 6);

        // Half duplex: one collision in the body, then a good retry.
        tries = 0; col_left = 1; col_at = 10;
        send(24, 0);
        wait_idle();
        chk(tries == 1 && ndone == 7, "R8", "retry after collision", ndone, 7);

        // Half duplex: collisions on every attempt until the limit.
        tries = 0; nexc = 0; col_left = MAXT; col_at = 3;
        send(8, 0);
        wait_idle();
        repeat (80) @(posedge clk);
        chk(tries == MAXT, "R10", "collisions seen", tries, MAXT);
        chk(nexc == 1, "R10", "excess collision pulses", nexc, 1);
        chk(ndone == 7, "R10", "no done after drop", ndone, 7);

        // Underrun: only three words present.
        avail_words = 3;
        send(40, 0);
        wait_idle();
        repeat (40) @(posedge clk);
        chk(ndone == 7, "R11", "no done after underrun", ndone, 7);
        avail_words = 100000;

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule